// File: doc/BRIEF.md
# Shared Interrupt Distributor for a Multicore Cluster

This block sits between a group of shared peripheral interrupt lines and the interrupt inputs of up to four processor cores. Every shared line is routed independently. It can go to a fixed set of cores, or it can be spread over a set of cores in turn, so that successive assertions are handled by different processors. Each line also has a trigger type (level or edge) and a mask bit. A single global enable gates the whole block.

Software sets up each line through a one-cycle command port. A strobe carries a command code, a line index and a data word. The block has one output wire per shared line per core. Shared line i lands on interrupt input 24+i of the core it is routed to. Each output is registered, so it follows its input one clock later.

Top module: `irq_distributor`

## Requirements
- R1: After reset, all outputs are low, every line is masked, every destination mask is zero, every line is in destination mode with level trigger, and every round-robin pointer holds core 0. The first round-robin grant on a full core mask therefore goes to core 1.
- R2: Until an enable command has been accepted, no output is driven, whatever the settings and inputs are.
- R3: When `cmd_valid` is high, the command is taken in that cycle. The codes are: 1 sets the destination mask (data[N_CORES-1:0], bit c selects core c), 2 sets the mode word, 3 sets the mask (data bit 0: 1 masks the line, 0 unmasks it), and 4 enables the block. Codes 0, 5, 6 and 7 have no effect. A command whose index is N_LINES or above has no effect.
- R4: In the mode word, bits [1:0] equal to 1 select round robin, and the values 0, 2 and 3 select destination mode. Bit 4 set to 1 selects level trigger and 0 selects edge trigger. All other bits are ignored.
- R5: A level line in destination mode drives only the lowest-numbered core in its mask. The output stays high for as long as the input stays high.
- R6: When a level line in round-robin mode is high and unowned, it is given to the next core after the previous owner, in ascending order with wraparound, skipping cores whose mask bit is clear. The owner keeps the output until the input falls.
- R7: A masked line drives no output. A line with an all-zero destination mask drives no output.
- R8: For an edge line, each rising input produces a one-cycle pulse. In destination mode the pulse goes to every core in the mask. In round-robin mode it goes to the next core, and the pointer advances.
- R9: `core_irq[c*N_LINES+i]` carries shared line i to core c. It responds one clock after the input or settings change.
- R10: If the current owner of a held round-robin level line is removed from the destination mask, the line moves to the next core still in the mask on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 3 | Command code |
| cmd_index | input | IDX_W | Shared line index |
| cmd_data | input | DATA_W | Command data word |
| irq_in | input | N_LINES | Shared interrupt inputs |
| core_irq | output | N_CORES*N_LINES | Routed outputs, bit c*N_LINES+i = line i to core c |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that reset is seen through the internal synchroniser, so no property is evaluated until two edges after `rst_n` rises. The one-cycle edge-pulse property assumes the trigger type has been stable for two cycles. The stimulus drives every input and command on the falling clock edge. It changes the trigger type only while the affected line is low. The only settings change made while a line is held is the deliberate owner removal under R10.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_DEST   = 3'd1,
    CMD_MODE   = 3'd2,
    CMD_MASK   = 3'd3,
    CMD_ENABLE = 3'd4
  } cmd_e;

  localparam int MODE_DIST_LSB = 0;
  localparam int MODE_LVL_BIT  = 4;
  localparam logic [1:0] DIST_RR = 2'd1;
endpackage

// File: rtl/irqd_rst_sync.sv
module irqd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqd_cfg.sv
module irqd_cfg
  import irqd_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int N_CORES = 4,
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  input  logic [2:0]                      cmd_code,
  input  logic [IDX_W-1:0]                cmd_index,
  input  logic [DATA_W-1:0]               cmd_data,
  output logic                            en_q,
  output logic [N_LINES-1:0]              mask_q,
  output logic [N_LINES-1:0]              rr_q,
  output logic [N_LINES-1:0]              lvl_q,
  output logic [N_LINES-1:0][N_CORES-1:0] dest_q
);
  localparam int LIDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [IDX_W-1:0] LINE_LIMIT = IDX_W'(N_LINES);

  logic                            en_n;
  logic [N_LINES-1:0]              mask_n, rr_n, lvl_n;
  logic [N_LINES-1:0][N_CORES-1:0] dest_n;
  logic                            idx_ok;
  logic [LIDX_W-1:0]               sel;
  logic                            cfg_we;
  logic                            unused_data;

  assign unused_data = ^cmd_data;
  assign idx_ok      = (cmd_index < LINE_LIMIT);
  assign sel         = cmd_index[LIDX_W-1:0];

  always_comb begin
    en_n   = en_q;
    mask_n = mask_q;
    rr_n   = rr_q;
    lvl_n  = lvl_q;
    dest_n = dest_q;
    cfg_we = 1'b0;
    if (cmd_valid) begin
      case (cmd_e'(cmd_code))
        CMD_DEST: if (idx_ok) begin
          dest_n[sel] = cmd_data[N_CORES-1:0];
          cfg_we      = 1'b1;
        end
        CMD_MODE: if (idx_ok) begin
          rr_n[sel]  = (cmd_data[MODE_DIST_LSB +: 2] == DIST_RR);
          lvl_n[sel] = cmd_data[MODE_LVL_BIT];
          cfg_we     = 1'b1;
        end
        CMD_MASK: if (idx_ok) begin
          mask_n[sel] = cmd_data[0];
          cfg_we      = 1'b1;
        end
        CMD_ENABLE: begin
          en_n   = 1'b1;
          cfg_we = 1'b1;
        end
        default: cfg_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
      rr_q   <= '0;
      lvl_q  <= '1;
      dest_q <= '0;
    end else if (cfg_we) begin
      en_q   <= en_n;
      mask_q <= mask_n;
      rr_q   <= rr_n;
      lvl_q  <= lvl_n;
      dest_q <= dest_n;
    end
  end
endmodule

// File: rtl/irqd_line.sv
module irqd_line #(
  parameter int N_CORES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               masked,
  input  logic               rr,
  input  logic               lvl,
  input  logic [N_CORES-1:0] dest,
  input  logic               irq,
  output logic [N_CORES-1:0] out
);
  localparam int PTR_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic               in_q, hold_q, hold_n;
  logic [PTR_W-1:0]   ptr_q, ptr_n, ptr_nxt, ptr_low;
  logic [N_CORES-1:0] out_q, out_n;
  logic               act, rise, ptr_en;

  function automatic logic [N_CORES-1:0] onehot(input logic [PTR_W-1:0] idx);
    logic [N_CORES-1:0] v;
    for (int c = 0; c < N_CORES; c++) v[c] = (c == int'(idx));
    return v;
  endfunction

  // next core after the current pointer that is set in the mask
  always_comb begin
    logic found;
    int   cand;
    found   = 1'b0;
    ptr_nxt = ptr_q;
    for (int k = 1; k <= N_CORES; k++) begin
      cand = (int'(ptr_q) + k) % N_CORES;
      if (!found && dest[cand]) begin
        found   = 1'b1;
        ptr_nxt = PTR_W'(cand);
      end
    end
  end

  // lowest set core in the mask
  always_comb begin
    ptr_low = '0;
    for (int c = N_CORES - 1; c >= 0; c--) begin
      if (dest[c]) ptr_low = PTR_W'(c);
    end
  end

  assign act  = en && !masked && (|dest);
  assign rise = irq && !in_q;

  always_comb begin
    hold_n = 1'b0;
    ptr_n  = ptr_q;
    out_n  = '0;
    if (lvl) begin
      if (act && irq) begin
        if (rr) begin
          hold_n = 1'b1;
          if (!(hold_q && dest[ptr_q])) ptr_n = ptr_nxt;
          out_n = onehot(ptr_n);
        end else begin
          out_n = onehot(ptr_low);
        end
      end
    end else if (act && rise) begin
      if (rr) begin
        ptr_n = ptr_nxt;
        out_n = onehot(ptr_nxt);
      end else begin
        out_n = dest;
      end
    end
  end

  assign ptr_en = (ptr_n != ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      hold_q <= 1'b0;
      out_q  <= '0;
    end else begin
      in_q   <= irq;
      hold_q <= hold_n;
      out_q  <= out_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  assign out = out_q;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int N_LINES = 8,
  parameter int N_CORES = 4,
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_code,
  input  logic [IDX_W-1:0]           cmd_index,
  input  logic [DATA_W-1:0]          cmd_data,
  input  logic [N_LINES-1:0]         irq_in,
  output logic [N_CORES*N_LINES-1:0] core_irq
);
  logic                            rst_int_n;
  logic                            en_q;
  logic [N_LINES-1:0]              mask_q, rr_q, lvl_q;
  logic [N_LINES-1:0][N_CORES-1:0] dest_q;
  logic [N_LINES-1:0][N_CORES-1:0] line_out;

  irqd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irqd_cfg #(
    .N_LINES (N_LINES),
    .N_CORES (N_CORES),
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_index (cmd_index),
    .cmd_data  (cmd_data),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .rr_q      (rr_q),
    .lvl_q     (lvl_q),
    .dest_q    (dest_q)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    irqd_line #(.N_CORES(N_CORES)) u_line (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en     (en_q),
      .masked (mask_q[i]),
      .rr     (rr_q[i]),
      .lvl    (lvl_q[i]),
      .dest   (dest_q[i]),
      .irq    (irq_in[i]),
      .out    (line_out[i])
    );
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign core_irq[c*N_LINES + i] = line_out[i][c];
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int N_LINES = 8,
  parameter int N_CORES = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            en,
  input logic [N_LINES-1:0]              mask,
  input logic [N_LINES-1:0]              lvl,
  input logic [N_LINES-1:0][N_CORES-1:0] dest,
  input logic [N_CORES*N_LINES-1:0]      core_irq
);
  p_quiet_until_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (core_irq == '0));

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    logic [N_CORES-1:0] line;
    for (genvar c = 0; c < N_CORES; c++) begin : g_bit
      assign line[c] = core_irq[c*N_LINES + i];
    end

    p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask[i] |=> (line == '0));

    p_dest_confined_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line & ~$past(dest[i])) == '0);

    p_level_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[i] |=> $onehot0(line));

    p_edge_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl[i] && !$past(lvl[i]) && (line != '0)) |=> (line == '0));
  end
endmodule

bind irq_distributor irqd_chk #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .en       (en_q),
  .mask     (mask_q),
  .lvl      (lvl_q),
  .dest     (dest_q),
  .core_irq (core_irq)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NL = 8;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [7:0]  cmd_index;
  logic [31:0] cmd_data;
  logic [NL-1:0]    irq_in;
  logic [NC*NL-1:0] core_irq;

  int n_checks = 0;
  int n_fail   = 0;

  irq_distributor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_index (cmd_index),
    .cmd_data  (cmd_data),
    .irq_in    (irq_in),
    .core_irq  (core_irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] bit_of(input int core, input int line);
    return 32'd1 << (core*NL + line);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: core_irq=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] code, input logic [7:0] idx, input logic [31:0] data);
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_index = idx;
    cmd_data  = data;
    step();
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
    cmd_data  = 32'd0;
  endtask

  task automatic t_reset_enable();
    check("R1 outputs low after reset", core_irq, 32'd0);
    irq_in[0] = 1'b1;
    step();
    check("R1 line masked after reset", core_irq, 32'd0);
    cmd(3'd1, 8'd0, 32'h1);
    cmd(3'd3, 8'd0, 32'h0);
    step();
    check("R2 no output before enable", core_irq, 32'd0);
    cmd(3'd4, 8'd0, 32'h0);
    step();
    check("R2 output after enable (R9 bit 0)", core_irq, bit_of(0, 0));
    irq_in[0] = 1'b0;
    step();
    check("R9 output follows input fall", core_irq, 32'd0);
  endtask

  task automatic t_level_dest();
    cmd(3'd1, 8'd2, 32'hC);
    cmd(3'd3, 8'd2, 32'h0);
    irq_in[2] = 1'b1;
    step();
    check("R5 lowest core of mask 1100", core_irq, bit_of(2, 2));
    step();
    check("R5 held while input high", core_irq, bit_of(2, 2));
    irq_in[2] = 1'b0;
    step();
    check("R5 released on fall", core_irq, 32'd0);
  endtask

  task automatic t_round_robin();
    cmd(3'd2, 8'd3, 32'h11);
    cmd(3'd1, 8'd3, 32'hF);
    cmd(3'd3, 8'd3, 32'h0);
    irq_in[3] = 1'b1;
    step();
    check("R1 pointer at core 0, first grant core 1", core_irq, bit_of(1, 3));
    step(); step();
    check("R6 owner held", core_irq, bit_of(1, 3));
    irq_in[3] = 1'b0;
    step();
    check("R6 released on fall", core_irq, 32'd0);
    irq_in[3] = 1'b1;
    step();
    check("R6 second grant core 2", core_irq, bit_of(2, 3));
    irq_in[3] = 1'b0;
    cmd(3'd1, 8'd3, 32'hB);
    irq_in[3] = 1'b1;
    step();
    check("R6 next after 2 in 1011 is core 3", core_irq, bit_of(3, 3));
    irq_in[3] = 1'b0;
    step();
    irq_in[3] = 1'b1;
    step();
    check("R6 wrap to core 0", core_irq, bit_of(0, 3));
    irq_in[3] = 1'b0;
    step();
    irq_in[3] = 1'b1;
    step();
    check("R6 then core 1", core_irq, bit_of(1, 3));
    cmd(3'd1, 8'd3, 32'h9);
    check("R10 owner kept on capture edge", core_irq, bit_of(1, 3));
    step();
    check("R10 owner removed, moves to core 3", core_irq, bit_of(3, 3));
    irq_in[3] = 1'b0;
    step();
    check("R10 released on fall", core_irq, 32'd0);
  endtask

  task automatic t_mask_zero();
    irq_in[2] = 1'b1;
    step();
    check("R7 line 2 live before mask", core_irq, bit_of(2, 2));
    cmd(3'd3, 8'd2, 32'h1);
    step();
    check("R7 masked line silent", core_irq, 32'd0);
    cmd(3'd3, 8'd2, 32'h0);
    step();
    check("R7 unmasked line returns", core_irq, bit_of(2, 2));
    cmd(3'd1, 8'd2, 32'h0);
    step();
    check("R7 zero destination silent", core_irq, 32'd0);
    irq_in[2] = 1'b0;
    step();
  endtask

  task automatic t_edge();
    cmd(3'd2, 8'd4, 32'h0);
    cmd(3'd1, 8'd4, 32'h6);
    cmd(3'd3, 8'd4, 32'h0);
    irq_in[4] = 1'b1;
    step();
    check("R8 edge destination pulse to cores 1,2", core_irq, bit_of(1, 4) | bit_of(2, 4));
    step();
    check("R8 edge pulse lasts one cycle", core_irq, 32'd0);
    irq_in[4] = 1'b0;
    cmd(3'd2, 8'd4, 32'h1);
    cmd(3'd1, 8'd4, 32'h5);
    irq_in[4] = 1'b1;
    step();
    check("R8 edge round robin to core 2", core_irq, bit_of(2, 4));
    step();
    check("R8 edge round robin pulse ends", core_irq, 32'd0);
    irq_in[4] = 1'b0;
    step();
    irq_in[4] = 1'b1;
    step();
    check("R8 edge round robin wraps to core 0", core_irq, bit_of(0, 4));
    irq_in[4] = 1'b0;
    step();
  endtask

  task automatic t_ignored();
    cmd(3'd1, 8'd0, 32'h2);
    cmd(3'd1, 8'd8, 32'h1);
    irq_in[0] = 1'b1;
    step();
    check("R3 out-of-range index ignored", core_irq, bit_of(1, 0));
    cmd(3'd0, 8'd0, 32'h1);
    cmd(3'd5, 8'd0, 32'h1);
    cmd(3'd6, 8'd0, 32'h1);
    cmd(3'd7, 8'd0, 32'h1);
    step();
    check("R3 undefined codes have no effect", core_irq, bit_of(1, 0));
    irq_in[0] = 1'b0;
    cmd(3'd2, 8'd5, 32'hFFFF_FFFD);
    cmd(3'd1, 8'd5, 32'hF);
    cmd(3'd3, 8'd5, 32'h0);
    irq_in[5] = 1'b1;
    step();
    check("R4 junk bits ignored, round robin core 1", core_irq, bit_of(1, 5));
    irq_in[5] = 1'b0;
    step();
    irq_in[5] = 1'b1;
    step();
    check("R4 round robin advances to core 2", core_irq, bit_of(2, 5));
    irq_in[5] = 1'b0;
    cmd(3'd2, 8'd5, 32'h13);
    irq_in[5] = 1'b1;
    step();
    check("R4 distribution 3 acts as destination", core_irq, bit_of(0, 5));
    irq_in[5] = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
    cmd_index = 8'd0;
    cmd_data  = 32'd0;
    irq_in    = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset_enable();
    t_level_dest();
    t_round_robin();
    t_mask_zero();
    t_edge();
    t_ignored();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule